// File: doc/BRIEF.md
# Cascadable 8/16-bit interval timer

This block holds two 8-bit up-counters that advance on a shared count-clock enable. Each counter is compared against its own compare latch. When the counter equals the latch on a count tick, the counter goes back to zero and the timer's interrupt flag is set. A timer's interrupt request output is high while both its flag and its enable are set. Software starts and stops each counter, sets the enables, and clears the flags through a small register port. Writes take effect at once. Reads return data one cycle after the address is presented.

In the independent (8-bit) mode the two timers are unrelated and drive separate request outputs. In the cascade (16-bit) mode the pair forms one 16-bit counter. The second counter advances when the first one rolls over from all-ones. The pair is compared against both data registers taken together, with the second timer's data register as the upper byte. Only the first timer's start bit, flag and request output take part in this mode.

Top module: `casc_timer`

## Requirements
- R1: After a synchronous reset every register reads as zero, both request outputs are low, and rd_data is zero.
- R2: Writing the run bit (bit 0 of a control register) from 0 to 1 clears that counter to zero and loads its compare latch from its data register. While running, each cycle with tick high either increments the counter or, when the counter already equals the latch, sets the flag and returns the counter to zero. This gives a period of latch+1 ticks.
- R3: The flag (bit 2) is set on a match regardless of the enable (bit 1). Each request output is the AND of a flag and an enable, updated on the same clock edge as they are. Raising the enable while the flag is set drives the request high on that write's edge.
- R4: Writing 0 to the flag bit clears the flag, and writing 1 leaves it unchanged. When a match and a clearing write fall on the same cycle, the flag ends up set.
- R5: If a write clears the run bit in the same cycle as a matching tick, the flag is not set and the counter keeps its value.
- R6: While the run bit is 0 the counter holds its value and ignores ticks. Setting the run bit again restarts the counter from zero.
- R7: The compare latch reloads from the data register only at start and at each match. A data write made during a period first changes the length of the following period.
- R8: With the cascade bit (bit 3 of control register 1) at 0, timer 1 drives irq_a and timer 2 drives irq_b, and the two timers count and flag independently of each other.
- R9: With the cascade bit at 1, the run bit of timer 1 starts the 16-bit pair from zero. The period is {data2,data1}+1 ticks. A match sets only timer 1's flag and drives only irq_a, while irq_b stays low and timer 2's flag stays clear.
- R10: The register addresses are: 0 control 1, 1 control 2, 2 data 1, 3 data 2, 4 counter 1, 5 counter 2. rd_data shows the addressed register one clock after rd_addr is applied, and unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-clock enable, one count per cycle it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| irq_a | output | 1 | Request from timer 1 or from the cascaded pair |
| irq_b | output | 1 | Request from timer 2, independent mode only |

## Verification
A wrong latch value or a wrong reload shows up at the request output as a period that is too short or too long. This is visible within latch+1 ticks, so the period is measured directly and compared with the arithmetic value for every compare value swept. A counter that is stuck, or one that drifts while stopped, can be read back through the counter addresses one cycle after the read address is applied. A broken carry in cascade mode moves the 16-bit period by 256 ticks or more, and any leakage into the second timer's path shows up as activity on irq_b.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int NT     = 2;

  localparam logic [ADDR_W-1:0] A_CTL1 = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTL2 = 3'd1;
  localparam logic [ADDR_W-1:0] A_DAT1 = 3'd2;
  localparam logic [ADDR_W-1:0] A_DAT2 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT1 = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT2 = 3'd5;

  // control register bit positions
  localparam int B_RUN = 0;
  localparam int B_IE  = 1;
  localparam int B_FLG = 2;
  localparam int B_CAS = 3;
endpackage

// File: rtl/ct_slice.sv
module ct_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] dat,
  output logic [W-1:0] cnt,
  output logic [W-1:0] lat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lat <= '0;
    end else if (load || clr) begin
      cnt <= '0;
      lat <= dat;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6
  load_zero_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == '0));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && !clr) |=> (cnt == W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/ct_seq.sv
module ct_seq
  import cascade_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 cas_q,
  input  logic [NT-1:0]        run_q,
  input  logic [NT-1:0]        halt,
  input  logic [NT-1:0]        load,
  input  logic [NT-1:0][W-1:0] cnt,
  input  logic [NT-1:0][W-1:0] lat,
  output logic [NT-1:0]        inc,
  output logic [NT-1:0]        clr,
  output logic [NT-1:0]        set_flg
);
  logic [NT-1:0] act;
  logic [NT-1:0] hit;
  logic [NT-1:0] inc8, clr8;
  logic          hit_wide, act_wide, low_full;

  for (genvar i = 0; i < NT; i++) begin : g_byte
    assign act[i]  = tick & run_q[i] & ~halt[i];
    assign hit[i]  = (cnt[i] == lat[i]);
    assign inc8[i] = act[i] & ~hit[i];
    assign clr8[i] = act[i] & hit[i];
  end

  assign act_wide = act[0];
  assign hit_wide = &hit;
  assign low_full = &cnt[0];

  always_comb begin
    if (cas_q) begin
      clr     = {NT{act_wide & hit_wide}};
      inc[0]  = act_wide & ~hit_wide;
      inc[1]  = act_wide & ~hit_wide & low_full;
      set_flg = {1'b0, act_wide & hit_wide};
    end else begin
      clr     = clr8;
      inc     = inc8;
      set_flg = clr8;
    end
  end

  // R2
  excl0_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({inc[0], clr[0], load[0]}));

  // R2
  excl1_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({inc[1], clr[1], load[1]}));

  // R9
  cas_flag2_chk: assert property (@(posedge clk) disable iff (rst)
    cas_q |-> !set_flg[1]);
endmodule

// File: rtl/ct_regs.sv
module ct_regs
  import cascade_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [NT-1:0][W-1:0] cnt,
  input  logic [NT-1:0]        set_flg,
  output logic [NT-1:0]        run_q,
  output logic [NT-1:0]        halt,
  output logic [NT-1:0]        load,
  output logic                 cas_q,
  output logic [NT-1:0][W-1:0] dat,
  output logic [W-1:0]         rd_data,
  output logic                 irq_a,
  output logic                 irq_b
);
  logic [NT-1:0] wr_ctl, start_p;
  logic [NT-1:0] run_nx, ie_q, ie_nx, flg_q, flg_nx;
  logic          cas_nx;
  logic [W-1:0]  rd_nx;

  assign wr_ctl[0] = wr_en && (wr_addr == A_CTL1);
  assign wr_ctl[1] = wr_en && (wr_addr == A_CTL2);

  for (genvar i = 0; i < NT; i++) begin : g_ctl
    assign start_p[i] = wr_ctl[i] & wr_data[B_RUN] & ~run_q[i];
    assign halt[i]    = wr_ctl[i] & ~wr_data[B_RUN];
    assign run_nx[i]  = wr_ctl[i] ? wr_data[B_RUN] : run_q[i];
    assign ie_nx[i]   = wr_ctl[i] ? wr_data[B_IE]  : ie_q[i];
    assign flg_nx[i]  = set_flg[i] | (flg_q[i] & ~(wr_ctl[i] & ~wr_data[B_FLG]));
  end

  assign cas_nx  = wr_ctl[0] ? wr_data[B_CAS] : cas_q;
  assign load[0] = start_p[0];
  assign load[1] = cas_nx ? start_p[0] : start_p[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      ie_q  <= '0;
      flg_q <= '0;
      cas_q <= 1'b0;
      irq_a <= 1'b0;
      irq_b <= 1'b0;
    end else begin
      run_q <= run_nx;
      ie_q  <= ie_nx;
      flg_q <= flg_nx;
      cas_q <= cas_nx;
      irq_a <= flg_nx[0] & ie_nx[0];
      irq_b <= flg_nx[1] & ie_nx[1] & ~cas_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dat <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_DAT1) dat[0] <= wr_data;
      if (wr_addr == A_DAT2) dat[1] <= wr_data;
    end
  end

  always_comb begin
    rd_nx = '0;
    case (rd_addr)
      A_CTL1: begin
        rd_nx[B_RUN] = run_q[0];
        rd_nx[B_IE]  = ie_q[0];
        rd_nx[B_FLG] = flg_q[0];
        rd_nx[B_CAS] = cas_q;
      end
      A_CTL2: begin
        rd_nx[B_RUN] = run_q[1];
        rd_nx[B_IE]  = ie_q[1];
        rd_nx[B_FLG] = flg_q[1];
      end
      A_DAT1:  rd_nx = dat[0];
      A_DAT2:  rd_nx = dat[1];
      A_CNT1:  rd_nx = cnt[0];
      A_CNT2:  rd_nx = cnt[1];
      default: rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nx;
  end

  // R4
  flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flg_q[0]) |-> $past(wr_ctl[0] && !wr_data[B_FLG]));

  // R5
  stop_match_chk: assert property (@(posedge clk) disable iff (rst)
    (halt[0] && !flg_q[0]) |=> !flg_q[0]);

  // R3
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_a) |-> (flg_q[0] && ie_q[0]));

  // R9
  cas_irqb_chk: assert property (@(posedge clk) disable iff (rst)
    cas_q |-> !irq_b);
endmodule

// File: rtl/casc_timer.sv
module casc_timer
  import cascade_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  output logic              irq_a,
  output logic              irq_b
);
  logic [NT-1:0][W-1:0] cnt, lat, dat;
  logic [NT-1:0]        run_q, halt, load, inc, clr, set_flg;
  logic                 cas_q;

  ct_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .cnt     (cnt),
    .set_flg (set_flg),
    .run_q   (run_q),
    .halt    (halt),
    .load    (load),
    .cas_q   (cas_q),
    .dat     (dat),
    .rd_data (rd_data),
    .irq_a   (irq_a),
    .irq_b   (irq_b)
  );

  ct_seq #(.W(W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cas_q   (cas_q),
    .run_q   (run_q),
    .halt    (halt),
    .load    (load),
    .cnt     (cnt),
    .lat     (lat),
    .inc     (inc),
    .clr     (clr),
    .set_flg (set_flg)
  );

  for (genvar i = 0; i < NT; i++) begin : g_slice
    ct_slice #(.W(W)) u_slice (
      .clk  (clk),
      .rst  (rst),
      .load (load[i]),
      .clr  (clr[i]),
      .inc  (inc[i]),
      .dat  (dat[i]),
      .cnt  (cnt[i]),
      .lat  (lat[i])
    );
  end
endmodule

// File: tb/casc_timer_tb.sv
`timescale 1ns/1ps
module casc_timer_tb;
  import cascade_timer_pkg::*;

  localparam logic [7:0] RUN = 8'h01;
  localparam logic [7:0] IE  = 8'h02;
  localparam logic [7:0] FLG = 8'h04;
  localparam logic [7:0] CAS = 8'h08;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic irq_a, irq_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  casc_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit tk = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic measure(input bit which, output int n);
    n = -1;
    for (int k = 1; k <= 70000; k++) begin
      pulse(1);
      if ((which ? irq_b : irq_a) === 1'b1) begin
        n = k;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    int cv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R10 addresses
    chk(irq_a == 1'b0 && irq_b == 1'b0, "R1 irq after reset", {irq_b, irq_a}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 8'h00, "R1 register reset value", v, 0);
    end

    // R2 R8 period sweep on each timer independently
    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < 17; i++) begin
        cv = (i == 16) ? 255 : i;
        wr(t ? A_DAT2 : A_DAT1, 8'(cv));
        wr(t ? A_CTL2 : A_CTL1, RUN | IE);
        measure(t[0], n);
        chk(n == cv + 1, "R2 R8 first period", n, cv + 1);
        wr(t ? A_CTL2 : A_CTL1, RUN | IE);
        chk((t ? irq_b : irq_a) == 1'b0, "R4 flag clear drops irq", int'(t ? irq_b : irq_a), 0);
        measure(t[0], n);
        chk(n == cv + 1, "R2 second period", n, cv + 1);
        chk((t ? irq_a : irq_b) == 1'b0, "R8 other irq idle", int'(t ? irq_a : irq_b), 0);
        wr(t ? A_CTL2 : A_CTL1, 8'h00);
      end
    end

    // R3 flag without enable, enable raise asserts irq at once
    wr(A_DAT1, 8'd4);
    wr(A_CTL1, RUN);
    pulse(5);
    chk(irq_a == 1'b0, "R3 no irq while disabled", irq_a, 0);
    rd(A_CTL1, v);
    chk(v == (RUN | FLG), "R3 flag set without enable", v, RUN | FLG);
    wr(A_CTL1, RUN | IE | FLG);
    chk(irq_a == 1'b1, "R3 enable raise gives irq", irq_a, 1);
    wr(A_CTL1, RUN | IE);
    rd(A_CTL1, v);
    chk(v == (RUN | IE), "R4 write 0 clears flag", v, RUN | IE);
    wr(A_CTL1, RUN | IE | FLG);
    rd(A_CTL1, v);
    chk(v == (RUN | IE), "R4 write 1 leaves flag clear", v, RUN | IE);
    chk(irq_a == 1'b0, "R4 write 1 gives no irq", irq_a, 0);
    wr(A_CTL1, 8'h00);

    // R4 set wins over a clearing write
    wr(A_DAT1, 8'd2);
    wr(A_CTL1, RUN | IE);
    pulse(2);
    wr(A_CTL1, RUN | IE, 1'b1);
    chk(irq_a == 1'b1, "R4 match beats clear", irq_a, 1);
    wr(A_CTL1, 8'h00);

    // R5 stop coinciding with match
    wr(A_DAT1, 8'd3);
    wr(A_CTL1, RUN | IE);
    pulse(3);
    wr(A_CTL1, IE, 1'b1);
    chk(irq_a == 1'b0, "R5 no irq on stop-match", irq_a, 0);
    rd(A_CTL1, v);
    chk(v == IE, "R5 flag clear on stop-match", v, IE);
    rd(A_CNT1, v);
    chk(v == 8'd3, "R5 counter held at match value", v, 3);
    // R6 hold and restart
    pulse(4);
    rd(A_CNT1, v);
    chk(v == 8'd3, "R6 stopped counter holds", v, 3);
    wr(A_CTL1, RUN | IE);
    rd(A_CNT1, v);
    chk(v == 8'd0, "R6 restart clears counter", v, 0);
    measure(1'b0, n);
    chk(n == 4, "R6 period after restart", n, 4);
    wr(A_CTL1, 8'h00);

    // R7 mid-count data write
    wr(A_DAT1, 8'd9);
    wr(A_CTL1, RUN | IE);
    pulse(3);
    wr(A_DAT1, 8'd2);
    measure(1'b0, n);
    chk(n == 7, "R7 current period keeps old latch", n, 7);
    wr(A_CTL1, RUN | IE);
    measure(1'b0, n);
    chk(n == 3, "R7 next period uses new data", n, 3);
    wr(A_CTL1, 8'h00);

    // R8 both timers concurrently
    wr(A_DAT1, 8'd3);
    wr(A_DAT2, 8'd5);
    wr(A_CTL1, RUN | IE);
    wr(A_CTL2, RUN | IE);
    for (int k = 1; k <= 12; k++) begin
      pulse(1);
      chk(irq_a == (k >= 4), "R8 timer1 concurrent", irq_a, int'(k >= 4));
      chk(irq_b == (k >= 6), "R8 timer2 concurrent", irq_b, int'(k >= 6));
    end
    wr(A_CTL1, 8'h00);
    wr(A_CTL2, 8'h00);

    // R9 cascade mode
    for (int j = 0; j < 3; j++) begin
      int lo, hi;
      lo = (j == 0) ? 5 : (j == 1) ? 255 : 0;
      hi = (j == 0) ? 1 : (j == 1) ? 0   : 2;
      wr(A_DAT1, 8'(lo));
      wr(A_DAT2, 8'(hi));
      wr(A_CTL2, IE);
      wr(A_CTL1, RUN | IE | CAS);
      measure(1'b0, n);
      chk(n == hi * 256 + lo + 1, "R9 cascade period", n, hi * 256 + lo + 1);
      chk(irq_b == 1'b0, "R9 irq_b idle in cascade", irq_b, 0);
      rd(A_CTL2, v);
      chk(v == IE, "R9 timer2 flag unused", v, IE);
      wr(A_CTL1, 8'h00);
      wr(A_CTL2, 8'h00);
    end

    // R10 read-back of data registers
    wr(A_DAT1, 8'hA5);
    wr(A_DAT2, 8'h3C);
    rd(A_DAT1, v);
    chk(v == 8'hA5, "R10 data1 readback", v, 8'hA5);
    rd(A_DAT2, v);
    chk(v == 8'h3C, "R10 data2 readback", v, 8'h3C);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule